// File: doc/BRIEF.md
# Window Watchdog with Reset Generator

This block produces the active-low system reset for a microcontroller and supervises it with a windowed watchdog. All timing is counted in slow internal cycles. One cycle is a fixed number of oscillator pulses, 32 by default. The oscillator pulses arrive as single-clock strobes on `osc_tick`, and the supply comparator arrives as a digital flag, `vcc_ok`.

Reset is released once the supply has stayed good for a delay. The watchdog then opens a long window for the first service. After that, every service must fall inside an open window that follows a closed window. A service is a filtered falling edge of a control-register bit. Any violation pulses reset for a short time, sets a sticky diagnosis flag and restarts the sequence with a long window.

Every reset also emits a one-clock strobe that clears the whole control register. The watchdog can be suspended while the load current is low, if the control register allows it. A flash-programming input can switch it off altogether.

Top module: `wdt_rstgen`

## Requirements
- R1: A cycle is 32 `osc_tick` pulses. While `vcc_ok` is high, `rst_out_n` stays low until 16 cycle ticks have been counted, and it rises on the 16th tick. The delay from raising `vcc_ok` to the rise is therefore more than 15 and at most 16 cycles.
- R2: `rst_out_n` goes low in the same clock period in which `vcc_ok` goes low. On the next rise of `vcc_ok` the 16-cycle delay starts again from zero.
- R3: After reset is released, and after every watchdog reset ends, a 32-cycle long open window runs. If no service arrives in it, the watchdog trips exactly 32 cycles after the window started.
- R4: A service is recognised only when `trig_bit` has been sampled high on two consecutive cycle ticks and then low on the next two. A single high sample is not a service.
- R5: After each valid service, a 12-cycle closed window runs and then a 20-cycle open window. A service detected on the last tick of the closed window counts as valid. Without a further service the watchdog trips 32 cycles after the service.
- R6: A service during the closed window, or no service by the end of an open window, trips the watchdog. A trip drives `rst_out_n` low for 4 cycles, sets `wd_rst_flag` and is followed by a long open window.
- R7: `wd_rst_flag` is 0 after power-up. Once set, it stays set until a one-clock `diag_read` pulse clears it.
- R8: Each time `rst_out_n` falls, whether from undervoltage or from a trip, `ctrl_clear` pulses high for exactly one clock, one clock later.
- R9: While `susp_en` and `low_load` are both high, the watchdog neither trips nor resets. When `low_load` falls, a full 32-cycle open window starts. With `susp_en` low, `low_load` has no effect.
- R10: While `flash_mode` is high, the watchdog never trips. When `flash_mode` is released, a 32-cycle long open window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| osc_tick | input | 1 | One-clock strobe per oscillator period |
| vcc_ok | input | 1 | Supply above reset threshold |
| trig_bit | input | 1 | Watchdog service bit from the control register |
| susp_en | input | 1 | Control bit allowing suspension at low load |
| low_load | input | 1 | Load current below the watchdog threshold |
| flash_mode | input | 1 | Disables the watchdog while high |
| diag_read | input | 1 | One-clock strobe: diagnosis word was read |
| rst_out_n | output | 1 | Active-low system reset |
| wd_rst_flag | output | 1 | Sticky watchdog-trip diagnosis flag |
| ctrl_clear | output | 1 | One-clock strobe clearing all control bits |

## Verification
The bench places services on the last tick of a closed window and on the last valid tick of an open window. A design that is off by one tick in either window would trip at one of these points or miss a trip. It sends a single-sample pulse on the service bit, which a filter that looks at edges without counting samples would take as a service. It times trip expiry after a suspension and after flash mode to the exact clock. A design that resumed into a short closed window would trip early. It also glitches the supply partway through the power-on delay, which exposes a delay counter that does not restart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [2:0] {
    WS_IDLE   = 3'd0,
    WS_LONG   = 3'd1,
    WS_CLOSED = 3'd2,
    WS_OPEN   = 3'd3,
    WS_TRIP   = 3'd4,
    WS_PAUSE  = 3'd5
  } wd_state_e;
endpackage

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
  parameter int OSC_DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  output logic cyc_tick
);
  localparam int DW = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(OSC_DIV - 1);

  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (osc_tick) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign cyc_tick = osc_tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_por.sv
module wdt_por #(
  parameter int POR_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_tick,
  input  logic vcc_ok,
  output logic por_done
);
  localparam int PW = (POR_CYC > 1) ? $clog2(POR_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(POR_CYC - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!vcc_ok) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (cyc_tick && !done_q) begin
      if (cnt_q == LAST) done_d = 1'b1;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  assign por_done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/wdt_trig_filt.sv
module wdt_trig_filt #(
  parameter int HI_SAMPLES = 2,
  parameter int LO_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_tick,
  input  logic trig_bit,
  output logic trig_pulse
);
  localparam int FW = HI_SAMPLES + LO_SAMPLES;
  localparam logic [FW-1:0] MATCH = FW'(((1 << HI_SAMPLES) - 1) << LO_SAMPLES);

  logic [FW-1:0] hist_q, hist_d;
  logic          pulse_q, pulse_d;

  always_comb begin
    hist_d  = hist_q;
    pulse_d = 1'b0;
    if (cyc_tick) begin
      hist_d  = {hist_q[FW-2:0], trig_bit};
      pulse_d = (hist_d == MATCH);
    end
  end

  assign trig_pulse = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      hist_q  <= hist_d;
      pulse_q <= pulse_d;
    end
  end
endmodule

// File: rtl/wdt_window.sv
module wdt_window
  import wdt_pkg::*;
#(
  parameter int LONG_CYC   = 32,
  parameter int CLOSED_CYC = 12,
  parameter int OPEN_CYC   = 20,
  parameter int TRIP_CYC   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_tick,
  input  logic por_done,
  input  logic wd_active,
  input  logic trig_pulse,
  output logic in_trip,
  output logic trip_set
);
  localparam int MAXL = (LONG_CYC > OPEN_CYC) ? LONG_CYC : OPEN_CYC;
  localparam int CW   = $clog2(MAXL + 1);
  localparam logic [CW-1:0] LONG_LAST   = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] CLOSED_LAST = CW'(CLOSED_CYC - 1);
  localparam logic [CW-1:0] OPEN_LAST   = CW'(OPEN_CYC - 1);
  localparam logic [CW-1:0] TRIP_LAST   = CW'(TRIP_CYC - 1);

  wd_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    trip_set = 1'b0;
    if (!por_done) begin
      st_d  = WS_IDLE;
      cnt_d = '0;
    end else if (!wd_active) begin
      st_d  = WS_PAUSE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        WS_IDLE, WS_PAUSE: begin
          st_d  = WS_LONG;
          cnt_d = '0;
        end
        WS_LONG: begin
          if (trig_pulse) begin
            st_d  = WS_CLOSED;
            cnt_d = '0;
          end else if (cyc_tick) begin
            if (cnt_q == LONG_LAST) begin
              st_d     = WS_TRIP;
              cnt_d    = '0;
              trip_set = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        WS_CLOSED: begin
          if (trig_pulse) begin
            st_d     = WS_TRIP;
            cnt_d    = '0;
            trip_set = 1'b1;
          end else if (cyc_tick) begin
            if (cnt_q == CLOSED_LAST) begin
              st_d  = WS_OPEN;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        WS_OPEN: begin
          if (trig_pulse) begin
            st_d  = WS_CLOSED;
            cnt_d = '0;
          end else if (cyc_tick) begin
            if (cnt_q == OPEN_LAST) begin
              st_d     = WS_TRIP;
              cnt_d    = '0;
              trip_set = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        WS_TRIP: begin
          if (cyc_tick) begin
            if (cnt_q == TRIP_LAST) begin
              st_d  = WS_LONG;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          st_d  = WS_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  assign in_trip = (st_q == WS_TRIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wdt_rstgen.sv
module wdt_rstgen #(
  parameter int OSC_DIV    = 32,
  parameter int POR_CYC    = 16,
  parameter int LONG_CYC   = 32,
  parameter int CLOSED_CYC = 12,
  parameter int OPEN_CYC   = 20,
  parameter int TRIP_CYC   = 4,
  parameter int HI_SAMPLES = 2,
  parameter int LO_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic vcc_ok,
  input  logic trig_bit,
  input  logic susp_en,
  input  logic low_load,
  input  logic flash_mode,
  input  logic diag_read,
  output logic rst_out_n,
  output logic wd_rst_flag,
  output logic ctrl_clear
);
  logic cyc_tick, por_done, trig_pulse, in_trip, trip_set, wd_active;
  logic flag_q, flag_d, rlow_q, rlow_d, clr_q, clr_d;

  wdt_tick_div #(.OSC_DIV(OSC_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cyc_tick(cyc_tick)
  );

  wdt_por #(.POR_CYC(POR_CYC)) u_por (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .vcc_ok(vcc_ok),
    .por_done(por_done)
  );

  wdt_trig_filt #(.HI_SAMPLES(HI_SAMPLES), .LO_SAMPLES(LO_SAMPLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .trig_bit(trig_bit),
    .trig_pulse(trig_pulse)
  );

  assign wd_active = !flash_mode && !(susp_en && low_load);

  wdt_window #(
    .LONG_CYC(LONG_CYC), .CLOSED_CYC(CLOSED_CYC),
    .OPEN_CYC(OPEN_CYC), .TRIP_CYC(TRIP_CYC)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .por_done(por_done),
    .wd_active(wd_active), .trig_pulse(trig_pulse),
    .in_trip(in_trip), .trip_set(trip_set)
  );

  assign rst_out_n = vcc_ok && por_done && !in_trip;

  always_comb begin
    flag_d = flag_q;
    if (trip_set)       flag_d = 1'b1;
    else if (diag_read) flag_d = 1'b0;
    rlow_d = !rst_out_n;
    clr_d  = rlow_d && !rlow_q;
  end

  assign wd_rst_flag = flag_q;
  assign ctrl_clear  = clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      rlow_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      rlow_q <= rlow_d;
      clr_q  <= clr_d;
    end
  end
endmodule

// File: rtl/wdt_rstgen_chk.sv
module wdt_rstgen_chk (
  input logic clk,
  input logic rst_n,
  input logic vcc_ok,
  input logic flash_mode,
  input logic diag_read,
  input logic rst_out_n,
  input logic wd_rst_flag,
  input logic ctrl_clear
);
  // R2: supply loss forces reset at once
  p_vcc_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_ok) |-> !rst_out_n);

  // R7: flag only clears on a read
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_rst_flag && !diag_read) |=> wd_rst_flag);

  // R6: the flag rises together with a reset pulse
  p_flag_with_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst_flag) |-> !rst_out_n);

  // R8: every reset entry issues a clear strobe
  p_clear_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |=> ctrl_clear);

  // R8: strobe lasts a single clock
  p_clear_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_clear |=> !ctrl_clear);

  // R10: no watchdog reset while flash mode holds
  p_flash_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_mode && $past(flash_mode) && $past(rst_out_n) && vcc_ok && $past(vcc_ok))
      |-> rst_out_n);
endmodule

bind wdt_rstgen wdt_rstgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .flash_mode(flash_mode),
  .diag_read(diag_read), .rst_out_n(rst_out_n), .wd_rst_flag(wd_rst_flag),
  .ctrl_clear(ctrl_clear)
);

// File: tb/wdt_rstgen_tb.sv
module wdt_rstgen_tb;
  logic clk = 1'b0;
  logic rst_n, osc_tick, vcc_ok, trig_bit, susp_en, low_load, flash_mode, diag_read;
  logic rst_out_n, wd_rst_flag, ctrl_clear;

  int cyc = 0;
  int clr_cnt = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int base;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (ctrl_clear === 1'b1) clr_cnt++;

  wdt_rstgen u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .vcc_ok(vcc_ok),
    .trig_bit(trig_bit), .susp_en(susp_en), .low_load(low_load),
    .flash_mode(flash_mode), .diag_read(diag_read), .rst_out_n(rst_out_n),
    .wd_rst_flag(wd_rst_flag), .ctrl_clear(ctrl_clear)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at edge %0d: got %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic at_edge(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  task automatic wait_rise(output int r);
    int n = 0;
    while (rst_out_n !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    r = cyc;
  endtask

  // service detected on the tick at edge t
  task automatic service_at(input int t);
    at_edge(t - 128); trig_bit = 1'b1;
    at_edge(t - 64);  trig_bit = 1'b0;
  endtask

  task automatic read_diag();
    @(negedge clk); diag_read = 1'b1;
    @(negedge clk); diag_read = 1'b0;
    chk("R7 flag cleared by read", wd_rst_flag, 1'b0);
  endtask

  // trip at edge x, reset low for len clocks
  task automatic expect_trip(input string tag, input int x, input int len, inout int b);
    int c0 = clr_cnt;
    at_edge(x - 1);     chk({tag, " no trip yet"}, rst_out_n, 1'b1);
    at_edge(x);         chk({tag, " trip"}, rst_out_n, 1'b0);
    chk("R6 flag set on trip", wd_rst_flag, 1'b1);
    at_edge(x + 2);     chk_int("R8 clear strobe on trip", clr_cnt - c0, 1, 1);
    at_edge(x + len - 1); chk("R6 reset held 4 cycles", rst_out_n, 1'b0);
    at_edge(x + len);   chk("R6 reset ends after 4 cycles", rst_out_n, 1'b1);
    b = x + len;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; osc_tick = 1'b1; vcc_ok = 1'b0; trig_bit = 1'b0;
    susp_en = 1'b0; low_load = 1'b0; flash_mode = 1'b0; diag_read = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset low during block reset", rst_out_n, 1'b0);
    chk("R7 flag clear at power-up", wd_rst_flag, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_por(output int b);
    int v, r;
    repeat (5) @(negedge clk);
    vcc_ok = 1'b1; v = cyc;
    wait_rise(r);
    chk_int("R1 power-on delay", r - v, 15 * 32 + 1, 16 * 32);
    chk_int("R8 clear strobe at power-up", clr_cnt, 1, 1);
    b = r;
  endtask

  task automatic t_long_timeout(inout int b);
    expect_trip("R3 long window", b + 1024, 128, b);
    repeat (50) @(negedge clk);
    chk("R7 flag still set before read", wd_rst_flag, 1'b1);
    read_diag();
  endtask

  task automatic t_boundary(inout int b);
    int t1, t2;
    t1 = b + 320;
    service_at(t1);
    t2 = t1 + 384;                      // last closed tick
    service_at(t2);
    at_edge(t2 + 1); chk("R5 service on last closed tick accepted", rst_out_n, 1'b1);
    expect_trip("R5 closed+open window", t2 + 1024, 128, b);
    read_diag();
  endtask

  task automatic t_early(inout int b);
    int t1, t2, t3;
    t1 = b + 320;
    service_at(t1);
    t2 = t1 + 384 + 32 * 19;            // last usable open tick
    service_at(t2);
    at_edge(t2 + 1); chk("R5 service on last open tick accepted", rst_out_n, 1'b1);
    t3 = t2 + 352;                      // 11th closed tick
    service_at(t3);
    expect_trip("R6 early service", t3 + 1, 127, b);
    read_diag();
  endtask

  task automatic t_filter(inout int b);
    at_edge(b + 32 * 9);  trig_bit = 1'b1;
    at_edge(b + 32 * 10); trig_bit = 1'b0;
    expect_trip("R4 single high sample ignored", b + 1024, 128, b);
    read_diag();
  endtask

  task automatic t_suspend(inout int b);
    int x;
    at_edge(b + 32 * 5); susp_en = 1'b1; low_load = 1'b1;
    x = b + 32 * 70;
    at_edge(x);
    chk("R9 no trip while suspended", rst_out_n, 1'b1);
    chk("R9 flag untouched while suspended", wd_rst_flag, 1'b0);
    low_load = 1'b0;
    expect_trip("R9 full window after resume", x + 1024, 128, b);
    read_diag();
    susp_en = 1'b0;
    at_edge(b + 32); low_load = 1'b1;
    expect_trip("R9 low load ignored without enable", b + 1024, 128, b);
    low_load = 1'b0;
    read_diag();
  endtask

  task automatic t_flash(inout int b);
    int x;
    at_edge(b + 32); flash_mode = 1'b1;
    x = b + 32 * 80;
    at_edge(x);
    chk("R10 no trip in flash mode", rst_out_n, 1'b1);
    chk("R10 flag untouched in flash mode", wd_rst_flag, 1'b0);
    flash_mode = 1'b0;
    expect_trip("R10 long window after flash", x + 1024, 128, b);
    read_diag();
  endtask

  task automatic t_vcc(inout int b);
    int c0, v, r;
    at_edge(b + 200);
    c0 = clr_cnt;
    vcc_ok = 1'b0;
    #1 chk("R2 reset low with supply drop", rst_out_n, 1'b0);
    repeat (3) @(negedge clk);
    chk_int("R8 clear strobe on undervoltage", clr_cnt - c0, 1, 1);
    vcc_ok = 1'b1;
    repeat (320) @(negedge clk);
    vcc_ok = 1'b0;
    repeat (2) @(negedge clk);
    vcc_ok = 1'b1; v = cyc;
    at_edge(v + 15 * 32);
    chk("R2 delay restarts after glitch", rst_out_n, 1'b0);
    wait_rise(r);
    chk_int("R2 full delay after glitch", r - v, 15 * 32 + 1, 16 * 32);
    b = r;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_por(base);
    t_long_timeout(base);
    t_boundary(base);
    t_early(base);
    t_filter(base);
    t_suspend(base);
    t_flash(base);
    t_vcc(base);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule